// File: doc/BRIEF.md
# Programmable Free-Running Clock Output Divider

This block derives a free-running output clock from the internal bus clock. One 8-bit control register sets three things: whether the output runs, the ratio of a 5-bit integer divider (1 to 32), and whether a fixed divide-by-16 stage follows that divider. The register sits behind a small register port with an address, a write strobe, write data and combinational read data. Software may read or write the register at any time.

The output is a single clock signal. At ratio 1 with the extra stage off, the output is the bus clock itself, passed through a gate that cannot glitch. At every other ratio the output comes from a registered counter chain. New settings are held back until the current output period has finished, so a write never produces a short pulse. When the output is disabled it stays low, and the chain is parked so that the next enable begins with a full period.

Top module: `freeclk_gen`

## Requirements
- R1: After reset the register reads 0x80: bit 7 (disable) is 1 and every other bit is 0. The clock output is low.
- R2: Bit 6 of the register always reads 0, and a write of 1 to it has no effect.
- R3: While bit 7 is 1 the clock output is held low. Writing 0 to bit 7 starts the output.
- R4: With bit 5 clear, the output period is (D+1) bus cycles, where D is the unsigned value in bits 4:0.
- R5: With bit 5 set, the output period is 16×(D+1) bus cycles.
- R6: When bit 5 is clear and D+1 is at least 2, the output is high for ceil((D+1)/2) cycles and low for the rest of the period. When bit 5 is set, the output is high for exactly half the period.
- R7: With D=0 and bit 5 clear, the output follows the bus clock: its period is one cycle and its high phase is half a cycle.
- R8: A change of D or of bit 5 made while the output runs takes effect at the next rising edge of the output. The period in progress finishes at its old length.
- R9: After bit 7 goes from 1 to 0, the first output period has its full high phase and its full period.
- R10: The register lives only at address CTRL_ADDR. A write to any other address changes nothing, and a read from any other address returns 0.
- R11: A read of CTRL_ADDR returns the last value written, with bit 6 forced to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W | Register address |
| regWe | input | 1 | Write strobe, sampled on the rising edge of clk |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr (combinational) |
| clkOut | output | 1 | Divided free-running clock |

## Verification
The hardest situation to reach is a settings change that lands partway through a running period, because its effect only shows one full output period later. The bench aligns itself to a rising edge of the output, waits two bus cycles, and then writes a new ratio. It checks that the period in progress keeps its old length and that the following period has the new length. A second hard case is the switch between the gated bus clock and the counter-driven output. The sweep over every divide value, with the prescale stage both on and off, passes through the ratio-1 bypass in both directions, and each step measures the high time and the period from the edges of the output.

// File: rtl/freeclk_pkg.sv
package freeclk_pkg;
  localparam int CTRL_W   = 8;
  localparam int DIS_BIT  = 7;
  localparam int RSV_BIT  = 6;
  localparam int PRE_BIT  = 5;
  localparam int DIV_W    = 5;
  localparam int PRE_DIV  = 16;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h80;
  localparam logic [CTRL_W-1:0] WR_MASK    = ~(CTRL_W'(1) << RSV_BIT);

  typedef struct packed {
    logic             run;
    logic             preOn;
    logic [DIV_W-1:0] divSel;
  } ctrlStb_t;
endpackage

// File: rtl/freeclk_ctrl.sv
module freeclk_ctrl
  import freeclk_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [CTRL_W-1:0] regWdata,
  output logic [CTRL_W-1:0] regRdata,
  output logic [CTRL_W-1:0] ctrlQ,
  output ctrlStb_t          stb
);
  logic hit;

  assign hit = (regAddr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ctrlQ <= CTRL_RESET;
    else if (regWe && hit) ctrlQ <= regWdata & WR_MASK;
  end

  assign regRdata   = hit ? ctrlQ : '0;
  assign stb.run    = ~ctrlQ[DIS_BIT];
  assign stb.preOn  = ctrlQ[PRE_BIT];
  assign stb.divSel = ctrlQ[DIV_W-1:0];
endmodule

// File: rtl/freeclk_div.sv
module freeclk_div
  import freeclk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  ctrlStb_t stb,
  output logic     clkOut
);
  localparam int PRE_W = $clog2(PRE_DIV);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [PRE_W-1:0] PRE_HALF = PRE_W'(PRE_DIV / 2);

  logic [DIV_W-1:0] cnt1, actDiv, nCnt1, nDiv;
  logic [PRE_W-1:0] cnt2, nCnt2;
  logic             actPre, nPre;
  logic             lastA, bound, nBypass, nOut;
  logic [DIV_W:0]   hiLen;
  logic             divOut, gateLow;

  always_comb begin
    lastA = (cnt1 == actDiv);
    bound = lastA && (!actPre || (cnt2 == PRE_LAST));
    if (bound) begin
      nDiv  = stb.divSel;
      nPre  = stb.preOn;
      nCnt1 = '0;
      nCnt2 = '0;
    end else begin
      nDiv  = actDiv;
      nPre  = actPre;
      nCnt1 = lastA ? '0 : cnt1 + 1'b1;
      nCnt2 = lastA ? cnt2 + 1'b1 : cnt2;
    end
    hiLen   = ({1'b0, nDiv} + (DIV_W+1)'(2)) >> 1;
    nBypass = (nDiv == '0) && !nPre;
    if (nBypass)   nOut = 1'b0;
    else if (nPre) nOut = (nCnt2 < PRE_HALF);
    else           nOut = ({1'b0, nCnt1} < hiLen);
  end

  // Parked state while disabled: last position of a period, so the next
  // enabled edge is a boundary that opens a full period.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt1   <= '0;
      actDiv <= '0;
      cnt2   <= PRE_LAST;
      actPre <= 1'b0;
      divOut <= 1'b0;
    end else if (!stb.run) begin
      cnt1   <= stb.divSel;
      actDiv <= stb.divSel;
      cnt2   <= PRE_LAST;
      actPre <= stb.preOn;
      divOut <= 1'b0;
    end else begin
      cnt1   <= nCnt1;
      actDiv <= nDiv;
      cnt2   <= nCnt2;
      actPre <= nPre;
      divOut <= nOut;
    end
  end

  // Gate select changes only while clk is low; both mux inputs are low then.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) gateLow <= 1'b0;
    else       gateLow <= stb.run && nBypass;
  end

  assign clkOut = (clk & gateLow) | (divOut & ~gateLow);
endmodule

// File: rtl/freeclk_gen.sv
module freeclk_gen
  import freeclk_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              clkOut
);
  ctrlStb_t          stb;
  logic [CTRL_W-1:0] ctrlQ;

  freeclk_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .ctrlQ(ctrlQ), .stb(stb)
  );

  freeclk_div i_div (
    .clk(clk), .rstN(rstN), .stb(stb), .clkOut(clkOut)
  );
endmodule

// File: rtl/freeclk_chk.sv
module freeclk_chk #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h2A
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [7:0]        regWdata,
  input logic [7:0]        regRdata,
  input logic              clkOut,
  input logic [7:0]        ctrlQ
);
  a_r2_rsv_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == CTRL_ADDR) |-> (regRdata[6] == 1'b0));

  a_r10_other_addr_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != CTRL_ADDR) |-> (regRdata == 8'h00));

  a_r11_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == CTRL_ADDR) |=> (ctrlQ == ($past(regWdata) & 8'hBF)));

  a_r3_low_when_off: assert property (@(negedge clk) disable iff (!rstN)
    (ctrlQ[7] && $past(ctrlQ[7])) |-> !clkOut);
endmodule

bind freeclk_gen freeclk_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) i_chk (.*);

// File: tb/test_freeclk_gen.sv
`timescale 1ns/1ps
module test_freeclk_gen;
  localparam logic [7:0] ADDR = 8'h2A;
  localparam int NV = 8;
  localparam logic [7:0] V_REG [NV] = '{8'h00, 8'h01, 8'h02, 8'h07, 8'h0A, 8'h1F, 8'h20, 8'h3F};
  localparam int V_PER [NV] = '{1, 2, 3, 8, 11, 32, 16, 512};
  localparam int V_HI  [NV] = '{2, 4, 8, 16, 24, 64, 32, 1024}; // ns

  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0;
  logic [7:0] regAddr = '0, regWdata = '0, regRdata;
  logic clkOut;
  int testCnt = 0, failCnt = 0;

  freeclk_gen i_freeclk_gen (.clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .clkOut(clkOut));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWe = 1'b1; regWdata = d;
    @(negedge clk); regWe = 1'b0; regAddr = ADDR;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
    regAddr = ADDR;
  endtask

  task automatic runCfg(input logic [7:0] v, input int per, input int hiNs, input string req);
    longint t0, t1, t2;
    wr(ADDR, v);
    @(posedge clkOut); @(posedge clkOut);
    t0 = $time;
    @(negedge clkOut); t1 = $time;
    @(posedge clkOut); t2 = $time;
    check(t2 - t0 == per * 4, req, t2 - t0, per * 4);
    check(t1 - t0 == hiNs, {req, " R6 high"}, t1 - t0, hiNs);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [7:0] d;
    longint t0, t1, t2;
    int highs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(ADDR, d);
    check(d == 8'h80, "R1 reset value", d, 8'h80);
    check(clkOut == 1'b0, "R1 output low", clkOut, 0);

    // R2 reserved bit, R11 readback
    wr(ADDR, 8'hFF); rd(ADDR, d);
    check(d == 8'hBF, "R2 bit6 ignored", d, 8'hBF);
    wr(ADDR, 8'hA5); rd(ADDR, d);
    check(d == 8'hA5, "R11 readback", d, 8'hA5);

    // R10 other address
    wr(8'h2B, 8'h00); rd(ADDR, d);
    check(d == 8'hA5, "R10 foreign write ignored", d, 8'hA5);
    rd(8'h2B, d);
    check(d == 8'h00, "R10 foreign read zero", d, 0);

    // R3 disabled output stays low (ratio 1 bypass selected underneath)
    wr(ADDR, 8'h80);
    highs = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1 if (clkOut) highs++;
      @(negedge clk); #1 if (clkOut) highs++;
    end
    check(highs == 0, "R3 held low", highs, 0);

    // R9 first period after enable, R3 release
    wr(ADDR, 8'h85); wr(ADDR, 8'h05);
    @(posedge clkOut); t0 = $time;
    @(negedge clkOut); t1 = $time;
    @(posedge clkOut); t2 = $time;
    check(t1 - t0 == 12, "R9 first high phase", t1 - t0, 12);
    check(t2 - t0 == 24, "R9 first period / R3 runs", t2 - t0, 24);

    // R8 mid-period change
    wr(ADDR, 8'h09);
    @(posedge clkOut); @(posedge clkOut); t0 = $time;
    repeat (2) @(negedge clk);
    regAddr = ADDR; regWe = 1'b1; regWdata = 8'h03;
    @(negedge clk); regWe = 1'b0;
    @(posedge clkOut); t1 = $time;
    @(posedge clkOut); t2 = $time;
    check(t1 - t0 == 40, "R8 old period kept", t1 - t0, 40);
    check(t2 - t1 == 16, "R8 new period", t2 - t1, 16);

    // Table of vectors: R4 R5 R6 R7
    for (int k = 0; k < NV; k++)
      runCfg(V_REG[k], V_PER[k], V_HI[k], V_REG[k][5] ? "R5 table" : (V_REG[k] == 0 ? "R7 table" : "R4 table"));

    // Sweep every divide value, prescale off and on
    for (int p = 0; p < 2; p++)
      for (int dv = 0; dv < 32; dv++) begin
        int r, per, hi;
        r   = dv + 1;
        per = p ? 16 * r : r;
        hi  = (r == 1 && p == 0) ? 2 : (p ? 32 * r : ((r + 1) / 2) * 4);
        runCfg(8'(dv) | (p ? 8'h20 : 8'h00), per, hi, p ? "R5 sweep" : "R4 sweep");
      end

    // R3 disable again after running
    wr(ADDR, 8'h80);
    repeat (3) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1 if (clkOut) highs++;
    end
    check(highs == 0, "R3 disable after run", highs, 0);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule